// File: doc/BRIEF.md
# Ethernet DMA Status and Interrupt Registers

This block holds the control and status registers that software uses to steer an Ethernet DMA engine. Its central register is the status word. The transmit and receive engines raise its sticky event bits through dedicated event inputs, and software clears them by writing ones. An interrupt-enable word masks the status, and a single level interrupt line is high whenever an enabled status bit is set.

The block also holds a bus-mode word, a control word, and a read-only identification constant. For each of the two descriptor rings it keeps a base address and a current-descriptor pointer. Writing a ring base also reloads that ring's current pointer. A write to the transmit poll register is not stored. It produces a single-cycle kick toward the transmit engine.

Software reaches the registers through a plain 32-bit port with a byte address. The word index is the byte address shifted right by two, and the two low address bits are ignored. Reads are combinational from the current register state. Writes take effect at the clock edge.

Top module: `eth_dma_csr`

## Requirements
- R1: The word index is the byte address shifted right by 2. The word map is: 0x3C0 bus mode, 0x3C1 transmit poll, 0x3C3 receive ring base, 0x3C4 transmit ring base, 0x3C5 status, 0x3C6 control, 0x3C7 interrupt enable, 0x3D2 current transmit pointer, 0x3D3 current receive pointer. A read returns the stored word in the same cycle, and a write is visible from the next cycle.
- R2: A write to status clears each bit that is one in the written value and leaves every other bit unchanged. A written one never sets a status bit.
- R3: `irq` is high exactly when status AND interrupt-enable is non-zero. It reflects the register state that a write or an event produces from the cycle after that write or event.
- R4: Bit 0 of the bus-mode word always reads zero. The other 31 bits store the written value.
- R5: Word index 8 reads the constant 0x1012, and writes to it have no effect.
- R6: Writing a ring base loads both the base and that ring's current pointer with the written value. Writing a current pointer directly changes only that pointer.
- R7: `ev_tx_done` sets status bit 0 and bit 16. `ev_rx_done` sets bit 6 and bit 16. `ev_rx_nobuf` sets bit 7 and bit 15.
- R8: A write to word 0x3C1 raises `tx_poll` for exactly the one cycle after the write. Nothing is stored, and the word reads zero.
- R9: When an event and a status clear hit the same bit in the same cycle, the bit ends up set.
- R10: Every word not listed in R1 or R5 (including 0x3C2) reads zero, and writes to it change no register.
- R11: Synchronous reset clears every stored word to zero and drives `irq` and `tx_poll` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address of the access |
| wr_en | input | 1 | Write strobe for the addressed word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` (combinational) |
| ev_tx_done | input | 1 | Transmit engine finished a frame |
| ev_rx_done | input | 1 | Receive engine stored a frame |
| ev_rx_nobuf | input | 1 | Receive engine found no free descriptor |
| irq | output | 1 | Level interrupt, enabled status non-zero |
| tx_poll | output | 1 | One-cycle kick to the transmit engine |

## Verification
The hardest case to reach is a status clear and an event landing on the same bit in one cycle. The bench produces it by first setting the bit with an event, then driving the matching event input in the same cycle as a write of ones to status. It then reads status back and checks that the bit survived while unrelated bits were cleared. Interrupt masking is handled in a similar way. Events are raised while enables are off, and `irq` is observed rising only at the moment the enable word is written.

// File: rtl/eth_dma_csr_pkg.sv
package eth_dma_csr_pkg;

    localparam int WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;

    // word indices (byte address >> 2)
    localparam int IDX_VERSION = 'h008;
    localparam int IDX_BUSMODE = 'h3C0;
    localparam int IDX_TXPOLL  = 'h3C1;
    localparam int IDX_RXBASE  = 'h3C3;
    localparam int IDX_TXBASE  = 'h3C4;
    localparam int IDX_STATUS  = 'h3C5;
    localparam int IDX_CTRL    = 'h3C6;
    localparam int IDX_IEN     = 'h3C7;
    localparam int IDX_CUR_TX  = 'h3D2;
    localparam int IDX_CUR_RX  = 'h3D3;

    // status bit positions
    localparam int ST_TXDONE  = 0;
    localparam int ST_RXDONE  = 6;
    localparam int ST_RXNOBUF = 7;
    localparam int ST_ABN_SUM = 15;
    localparam int ST_NRM_SUM = 16;

    localparam int RING_TX = 0;
    localparam int RING_RX = 1;
    localparam int N_RINGS = 2;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_VERSION, SEL_BUSMODE, SEL_TXPOLL, SEL_RXBASE,
        SEL_TXBASE, SEL_STATUS, SEL_CTRL, SEL_IEN, SEL_CUR_TX, SEL_CUR_RX
    } reg_sel_e;

    typedef struct packed {
        logic tx_done;
        logic rx_done;
        logic rx_nobuf;
    } dma_evt_t;

    function automatic word_t evt_set_mask(dma_evt_t ev);
        word_t m;
        m = '0;
        m[ST_TXDONE]  = ev.tx_done;
        m[ST_RXDONE]  = ev.rx_done;
        m[ST_RXNOBUF] = ev.rx_nobuf;
        m[ST_NRM_SUM] = ev.tx_done | ev.rx_done;
        m[ST_ABN_SUM] = ev.rx_nobuf;
        return m;
    endfunction

endpackage

// File: rtl/eth_dma_decode.sv
module eth_dma_decode
    import eth_dma_csr_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] widx;
    logic [1:0]       unused_byte_lane;
    int unsigned      w;

    assign widx             = addr[ADDR_W-1:2];
    assign unused_byte_lane = addr[1:0];
    assign w                = 32'(widx);

    always_comb begin
        case (w)
            IDX_VERSION: sel = SEL_VERSION;
            IDX_BUSMODE: sel = SEL_BUSMODE;
            IDX_TXPOLL:  sel = SEL_TXPOLL;
            IDX_RXBASE:  sel = SEL_RXBASE;
            IDX_TXBASE:  sel = SEL_TXBASE;
            IDX_STATUS:  sel = SEL_STATUS;
            IDX_CTRL:    sel = SEL_CTRL;
            IDX_IEN:     sel = SEL_IEN;
            IDX_CUR_TX:  sel = SEL_CUR_TX;
            IDX_CUR_RX:  sel = SEL_CUR_RX;
            default:     sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/eth_dma_status.sv
module eth_dma_status
    import eth_dma_csr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr_we,
    input  word_t    clr_mask,
    input  dma_evt_t ev,
    input  word_t    ien,
    output word_t    status,
    output logic     irq
);
    word_t kept;

    always_comb begin
        kept = status;
        if (clr_we) kept = status & ~clr_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= kept | evt_set_mask(ev);
    end

    assign irq = |(status & ien);

    // R2: cleared bits are gone when no event is present
    assert_w1c_R2: assert property (@(posedge clk) disable iff (rst)
        (clr_we && ev == '0) |=> ((status & $past(clr_mask)) == '0));

    // R7: transmit completion sets its bit and normal summary
    assert_txdone_sets_R7: assert property (@(posedge clk) disable iff (rst)
        ev.tx_done |=> (status[ST_TXDONE] && status[ST_NRM_SUM]));

    // R9: event beats a simultaneous clear
    assert_event_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (ev.rx_nobuf && clr_we && clr_mask[ST_RXNOBUF]) |=> status[ST_RXNOBUF]);

    // R3: enabled event raises the interrupt next cycle
    assert_irq_follows_R3: assert property (@(posedge clk) disable iff (rst)
        (ev.rx_done && ien[ST_RXDONE] && $stable(ien)) |=> irq);
endmodule

// File: rtl/eth_dma_ring_ptr.sv
module eth_dma_ring_ptr
    import eth_dma_csr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  base_we,
    input  logic  cur_we,
    input  word_t wdata,
    output word_t base,
    output word_t cur
);
    always_ff @(posedge clk) begin
        if (rst) begin
            base <= '0;
            cur  <= '0;
        end else if (base_we) begin
            base <= wdata;
            cur  <= wdata;
        end else if (cur_we) begin
            cur  <= wdata;
        end
    end

    // R6: a base write lands in both base and current pointer
    assert_base_loads_cur_R6: assert property (@(posedge clk) disable iff (rst)
        base_we |=> (cur == $past(wdata) && base == $past(wdata)));
endmodule

// File: rtl/eth_dma_csr.sv
module eth_dma_csr
    import eth_dma_csr_pkg::*;
#(
    parameter int          ADDR_W     = 12,
    parameter logic [31:0] VERSION_ID = 32'h0000_1012
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    input  logic              ev_tx_done,
    input  logic              ev_rx_done,
    input  logic              ev_rx_nobuf,
    output logic              irq,
    output logic              tx_poll
);
    reg_sel_e sel;
    dma_evt_t ev;
    word_t    bus_mode_q, ctrl_q, ien_q, status_q;
    logic [N_RINGS-1:0] base_we, cur_we;
    word_t [N_RINGS-1:0] base_q, cur_q;

    assign ev = '{tx_done: ev_tx_done, rx_done: ev_rx_done, rx_nobuf: ev_rx_nobuf};

    eth_dma_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(addr), .sel(sel));

    assign base_we[RING_TX] = wr_en && sel == SEL_TXBASE;
    assign base_we[RING_RX] = wr_en && sel == SEL_RXBASE;
    assign cur_we[RING_TX]  = wr_en && sel == SEL_CUR_TX;
    assign cur_we[RING_RX]  = wr_en && sel == SEL_CUR_RX;

    for (genvar g = 0; g < N_RINGS; g++) begin : g_ring
        eth_dma_ring_ptr u_ring (
            .clk(clk), .rst(rst),
            .base_we(base_we[g]), .cur_we(cur_we[g]),
            .wdata(wr_data), .base(base_q[g]), .cur(cur_q[g])
        );
    end

    eth_dma_status u_stat (
        .clk(clk), .rst(rst),
        .clr_we(wr_en && sel == SEL_STATUS), .clr_mask(wr_data),
        .ev(ev), .ien(ien_q), .status(status_q), .irq(irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_mode_q <= '0;
            ctrl_q     <= '0;
            ien_q      <= '0;
            tx_poll    <= 1'b0;
        end else begin
            tx_poll <= wr_en && sel == SEL_TXPOLL;
            if (wr_en && sel == SEL_BUSMODE) bus_mode_q <= {wr_data[31:1], 1'b0};
            if (wr_en && sel == SEL_CTRL)    ctrl_q     <= wr_data;
            if (wr_en && sel == SEL_IEN)     ien_q      <= wr_data;
        end
    end

    always_comb begin
        case (sel)
            SEL_VERSION: rd_data = VERSION_ID;
            SEL_BUSMODE: rd_data = bus_mode_q;
            SEL_RXBASE:  rd_data = base_q[RING_RX];
            SEL_TXBASE:  rd_data = base_q[RING_TX];
            SEL_STATUS:  rd_data = status_q;
            SEL_CTRL:    rd_data = ctrl_q;
            SEL_IEN:     rd_data = ien_q;
            SEL_CUR_TX:  rd_data = cur_q[RING_TX];
            SEL_CUR_RX:  rd_data = cur_q[RING_RX];
            default:     rd_data = '0;
        endcase
    end

    // R4: bus-mode bit 0 never holds a one after a write
    assert_busmode_lsb_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_BUSMODE) |=> !bus_mode_q[0]);

    // R8: the poll kick only follows a poll write
    assert_poll_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        tx_poll |-> $past(wr_en && sel == SEL_TXPOLL));
endmodule

// File: tb/tb_eth_dma_csr.sv
module tb_eth_dma_csr;
    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] addr;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        ev_tx_done, ev_rx_done, ev_rx_nobuf;
    logic        irq, tx_poll;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural model state
    logic [31:0] m_bus, m_ctrl, m_ien, m_st, m_rxb, m_txb, m_crx, m_ctx;
    logic        m_poll;

    always #5 clk = ~clk;

    eth_dma_csr dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .ev_tx_done(ev_tx_done), .ev_rx_done(ev_rx_done),
        .ev_rx_nobuf(ev_rx_nobuf), .irq(irq), .tx_poll(tx_poll)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(int idx);
        case (idx)
            'h008: return 32'h0000_1012;
            'h3C0: return m_bus;
            'h3C3: return m_rxb;
            'h3C4: return m_txb;
            'h3C5: return m_st;
            'h3C6: return m_ctrl;
            'h3C7: return m_ien;
            'h3D2: return m_ctx;
            'h3D3: return m_crx;
            default: return 32'h0;
        endcase
    endfunction

    task automatic m_reset();
        m_bus = 0; m_ctrl = 0; m_ien = 0; m_st = 0;
        m_rxb = 0; m_txb = 0; m_crx = 0; m_ctx = 0; m_poll = 0;
    endtask

    // one clock: drive at negedge, update model at edge, compare at next negedge
    task automatic step(bit we, int idx, logic [31:0] d, bit t, bit r, bit n, string req);
        logic [31:0] ns;
        wr_en = we; addr = 12'(idx * 4); wr_data = d;
        ev_tx_done = t; ev_rx_done = r; ev_rx_nobuf = n;
        @(posedge clk);
        ns = m_st;
        m_poll = 0;
        if (we) begin
            case (idx)
                'h3C0: m_bus = d & 32'hFFFF_FFFE;
                'h3C1: m_poll = 1;
                'h3C3: begin m_rxb = d; m_crx = d; end
                'h3C4: begin m_txb = d; m_ctx = d; end
                'h3C5: ns = m_st & ~d;
                'h3C6: m_ctrl = d;
                'h3C7: m_ien = d;
                'h3D2: m_ctx = d;
                'h3D3: m_crx = d;
                default: ;
            endcase
        end
        if (t) ns = ns | 32'h0001_0001;
        if (r) ns = ns | 32'h0001_0040;
        if (n) ns = ns | 32'h0000_8080;
        m_st = ns;
        @(negedge clk);
        wr_en = 0; ev_tx_done = 0; ev_rx_done = 0; ev_rx_nobuf = 0;
        chk({req, " irq R3"}, 32'(irq), 32'(|(m_st & m_ien)));
        chk({req, " poll R8"}, 32'(tx_poll), 32'(m_poll));
    endtask

    task automatic rd(int idx, string req);
        wr_en = 0; addr = 12'(idx * 4);
        #1;
        chk(req, rd_data, m_read(idx));
    endtask

    task automatic idle(int k);
        for (int i = 0; i < k; i++) step(0, 0, 0, 0, 0, 0, "idle");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1; wr_en = 0; addr = 0; wr_data = 0;
        ev_tx_done = 0; ev_rx_done = 0; ev_rx_nobuf = 0;
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R11 reset state
        chk("R11 irq", 32'(irq), 0);
        chk("R11 poll", 32'(tx_poll), 0);
        foreach (m_ctx[i]) ; // no-op
        rd('h3C0, "R11 busmode"); rd('h3C5, "R11 status"); rd('h3C7, "R11 ien");
        rd('h3D2, "R11 cur tx"); rd('h3D3, "R11 cur rx");
        rd('h008, "R5 version");

        // R4 / R1
        step(1, 'h3C0, 32'hFFFF_FFFF, 0, 0, 0, "R4");
        rd('h3C0, "R4 busmode lsb zero");
        step(1, 'h3C6, 32'h0000_2002, 0, 0, 0, "R1");
        rd('h3C6, "R1 control");

        // R6 ring bases
        step(1, 'h3C3, 32'h1000_0040, 0, 0, 0, "R6");
        rd('h3C3, "R6 rx base"); rd('h3D3, "R6 cur rx");
        step(1, 'h3C4, 32'h2000_0080, 0, 0, 0, "R6");
        rd('h3C4, "R6 tx base"); rd('h3D2, "R6 cur tx");
        step(1, 'h3D2, 32'h2000_00A0, 0, 0, 0, "R6");
        rd('h3D2, "R6 cur tx direct"); rd('h3C4, "R6 tx base kept");

        // R7 events, enables off so irq stays low (R3)
        step(0, 0, 0, 1, 0, 0, "R7 tx");
        rd('h3C5, "R7 tx done bits");
        step(0, 0, 0, 0, 1, 0, "R7 rx");
        rd('h3C5, "R7 rx done bits");
        step(0, 0, 0, 0, 0, 1, "R7 nobuf");
        rd('h3C5, "R7 nobuf bits");

        // R3 enable raises irq
        step(1, 'h3C7, 32'h0000_0001, 0, 0, 0, "R3 enable");
        chk("R3 irq high", 32'(irq), 1);
        // R2 clear bit 0 only
        step(1, 'h3C5, 32'h0000_0001, 0, 0, 0, "R2 clear");
        rd('h3C5, "R2 status after clear");
        chk("R3 irq low after clear", 32'(irq), 0);

        // R9 event against clear on the same bit
        step(1, 'h3C7, 32'h0000_0080, 0, 0, 0, "R3 ien nobuf");
        step(1, 'h3C5, 32'hFFFF_FFFF, 0, 0, 1, "R9 clash");
        rd('h3C5, "R9 bit survives clash");
        chk("R9 irq stays", 32'(irq), 1);
        step(1, 'h3C5, 32'hFFFF_FFFF, 0, 0, 0, "R2 clear all");
        rd('h3C5, "R2 status zero");
        step(1, 'h3C5, 32'h0000_0000, 0, 1, 0, "R2 zero write");
        rd('h3C5, "R2 zero write keeps");

        // R8 poll kick
        step(1, 'h3C1, 32'hDEAD_BEEF, 0, 0, 0, "R8 poll write");
        chk("R8 pulse high", 32'(tx_poll), 1);
        rd('h3C1, "R8 poll reads zero");
        step(0, 0, 0, 0, 0, 0, "R8 after");
        chk("R8 pulse gone", 32'(tx_poll), 0);

        // R10 / R5 ignored writes
        step(1, 'h3C2, 32'h1234_5678, 0, 0, 0, "R10");
        rd('h3C2, "R10 rx poll reads zero");
        step(1, 'h100, 32'h1234_5678, 0, 0, 0, "R10");
        rd('h100, "R10 hole reads zero");
        rd('h3C0, "R10 busmode untouched"); rd('h3C7, "R10 ien untouched");
        step(1, 'h008, 32'hFFFF_FFFF, 0, 0, 0, "R5");
        rd('h008, "R5 version constant");

        // mixed events, enable all
        step(1, 'h3C7, 32'hFFFF_FFFF, 1, 1, 1, "R7 all");
        rd('h3C5, "R7 all bits");
        step(1, 'h3C7, 32'h0, 0, 0, 0, "R3 disable");
        chk("R3 irq low disabled", 32'(irq), 0);
        idle(3);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule